// File: doc/BRIEF.md
# C/I Channel Change-Detect Controller

This block serves the command/indication slot of a time-division framed line interface. On the transmit side the host writes a code once. The block then presents that code on the parallel slot output in every frame until the host writes a different code. On the receive side the block samples the slot on every frame strobe, without being armed by the host. It accepts a code only when that code has arrived in two consecutive frames and differs from the code it accepted last. This filtering stops a single corrupted frame, or a line that flips between two codes, from reaching the host as a state change.

An accepted code is held in a receive register that the host can read. Each acceptance sets an interrupt-pending flag, which the host clears with an acknowledge pulse. A mask input gates only the interrupt pin, so the pending flag is kept while the mask is off. A loopback input feeds the transmit code into the receive filter in place of the line data. An enable input switches the whole channel on. Turning serialisation into bits on the line is the job of a neighbouring block.

Top module: `ci_chan_ctrl`

## Requirements
- R1: One cycle after a host write pulse, `tx_slot_data` carries the written code, and it holds that code until the next write. While `chan_en` is low, `tx_slot_data` is all ones.
- R2: After reset, `host_rdata` is all ones, the stored transmit code is all ones, no interrupt is pending and `irq` is low.
- R3: While `chan_en` is high, every `slot_stb` pulse samples the slot. The sample becomes the new candidate when it differs from the current candidate or when no candidate is held.
- R4: When a sample equals the held candidate and differs from the accepted code, it becomes the accepted code. The new code appears on `host_rdata` in the cycle after the second strobe.
- R5: A code that is received twice in a row but equals the already accepted code changes nothing and raises no interrupt.
- R6: A code that alternates with another code on every frame is never accepted.
- R7: Every acceptance sets the pending flag. `irq` equals the pending flag ANDed with `irq_mask`. Clearing `irq_mask` hides the interrupt but keeps the pending flag.
- R8: An `irq_ack` pulse clears the pending flag in the next cycle. If an acceptance happens in the same cycle as the acknowledge, the flag stays set.
- R9: With `loop_en` high, the receive filter samples the stored transmit code and ignores `rx_slot_data`.
- R10: While `chan_en` is low, strobes change neither the accepted code nor the pending flag, and the held candidate is dropped. A code seen once before a disable and once after it is therefore not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable |
| loop_en | input | 1 | Feeds the transmit code into the receiver |
| slot_stb | input | 1 | One-cycle pulse per frame marking the C/I slot |
| rx_slot_data | input | CODE_W | Received slot code |
| tx_slot_data | output | CODE_W | Code to transmit in the slot |
| host_wr | input | 1 | Host write strobe for the transmit code |
| host_wdata | input | CODE_W | Transmit code from the host |
| host_rdata | output | CODE_W | Last accepted receive code |
| irq_mask | input | 1 | Interrupt enable, 1 lets the pending flag reach `irq` |
| irq_ack | input | 1 | Clears the pending flag |
| irq | output | 1 | Masked interrupt |

## Verification
Every result is due exactly one clock after the edge that causes it. The transmit code follows a write one cycle later. The accepted code and the pending flag change on the edge that samples the second matching strobe. `irq` then follows combinationally from the pending flag and the mask. The bench drives all inputs just after a falling edge, holds them for one rising edge, and compares the outputs at the next falling edge against a model updated for that same rising edge. The bench sweeps every ordered pair of 4-bit codes, so acceptance and non-acceptance are both exercised from every starting state.

// File: rtl/ci_pkg.sv
package ci_pkg;
   localparam int CI_MAX_W = 8;

   typedef enum logic [1:0] {
      CI_IDLE   = 2'd0,
      CI_LOAD   = 2'd1,
      CI_HOLD   = 2'd2,
      CI_COMMIT = 2'd3
   } ci_step_e;
endpackage

// File: rtl/ci_tx_hold.sv
module ci_tx_hold #(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr,
   input  logic [CODE_W-1:0] wdata,
   output logic [CODE_W-1:0] code_q,
   output logic [CODE_W-1:0] slot_o
);
   localparam logic [CODE_W-1:0] IDLE_CODE = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  code_q <= IDLE_CODE;
      else if (wr) code_q <= wdata;
   end

   assign slot_o = en ? code_q : IDLE_CODE;
endmodule

// File: rtl/ci_rx_filter.sv
module ci_rx_filter
   import ci_pkg::*;
#(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              stb,
   input  logic [CODE_W-1:0] smp,
   output logic [CODE_W-1:0] acc_q,
   output logic              commit_o
);
   localparam logic [CODE_W-1:0] IDLE_CODE = '1;

   logic [CODE_W-1:0] cand_q;
   logic              cand_vld_q;
   ci_step_e          step;

   always_comb begin
      if (!en || !stb)                        step = CI_IDLE;
      else if (!cand_vld_q || smp != cand_q)  step = CI_LOAD;
      else if (smp != acc_q)                  step = CI_COMMIT;
      else                                    step = CI_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q     <= IDLE_CODE;
         cand_vld_q <= 1'b0;
         acc_q      <= IDLE_CODE;
      end else begin
         if (!en) cand_vld_q <= 1'b0;
         case (step)
            CI_LOAD: begin
               cand_q     <= smp;
               cand_vld_q <= 1'b1;
            end
            CI_COMMIT: acc_q <= smp;
            default: ;
         endcase
      end
   end

   assign commit_o = (step == CI_COMMIT);
endmodule

// File: rtl/ci_irq_flag.sv
module ci_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic ack_i,
   input  logic mask_i,
   output logic pend_q,
   output logic irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (set_i)  pend_q <= 1'b1;
      else if (ack_i)  pend_q <= 1'b0;
   end

   assign irq_o = pend_q & mask_i;
endmodule

// File: rtl/ci_chan_ctrl.sv
module ci_chan_ctrl
   import ci_pkg::*;
#(
   parameter int CODE_W       = 4,
   parameter bit LOOP_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              loop_en,
   input  logic              slot_stb,
   input  logic [CODE_W-1:0] rx_slot_data,
   output logic [CODE_W-1:0] tx_slot_data,
   input  logic              host_wr,
   input  logic [CODE_W-1:0] host_wdata,
   output logic [CODE_W-1:0] host_rdata,
   input  logic              irq_mask,
   input  logic              irq_ack,
   output logic              irq
);
   logic [CODE_W-1:0] tx_code;
   logic [CODE_W-1:0] rx_smp;
   logic              commit;
   logic              irq_pend;

   if (CODE_W < 1 || CODE_W > CI_MAX_W) begin : g_bad_width
      $error("ci_chan_ctrl: CODE_W out of range");
   end

   ci_tx_hold #(.CODE_W(CODE_W)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (chan_en),
      .wr     (host_wr),
      .wdata  (host_wdata),
      .code_q (tx_code),
      .slot_o (tx_slot_data)
   );

   if (LOOP_SUPPORT) begin : g_loop
      assign rx_smp = loop_en ? tx_code : rx_slot_data;
   end else begin : g_noloop
      logic unused_loop;
      assign unused_loop = loop_en;
      assign rx_smp      = rx_slot_data;
   end

   ci_rx_filter #(.CODE_W(CODE_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (chan_en),
      .stb      (slot_stb),
      .smp      (rx_smp),
      .acc_q    (host_rdata),
      .commit_o (commit)
   );

   ci_irq_flag u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (commit),
      .ack_i  (irq_ack),
      .mask_i (irq_mask),
      .pend_q (irq_pend),
      .irq_o  (irq)
   );
endmodule

// File: rtl/ci_chan_checker.sv
module ci_chan_checker #(
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chan_en,
   input logic              slot_stb,
   input logic              host_wr,
   input logic [CODE_W-1:0] host_wdata,
   input logic [CODE_W-1:0] tx_slot_data,
   input logic [CODE_W-1:0] host_rdata,
   input logic              irq_mask,
   input logic              irq_ack,
   input logic              irq_pend,
   input logic              irq
);
   AST_TX_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |=> (!chan_en || tx_slot_data == $past(host_wdata))); // R1

   AST_ACC_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_stb || !chan_en) |=> $stable(host_rdata)); // R10

   AST_ACC_CHANGE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rdata != $past(host_rdata)) |-> irq_pend); // R7

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_mask |-> !irq); // R7

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> (!irq_pend || host_rdata != $past(host_rdata))); // R8

   AST_PEND_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pend) |-> host_rdata != $past(host_rdata)); // R5
endmodule

bind ci_chan_ctrl ci_chan_checker #(.CODE_W(CODE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .chan_en      (chan_en),
   .slot_stb     (slot_stb),
   .host_wr      (host_wr),
   .host_wdata   (host_wdata),
   .tx_slot_data (tx_slot_data),
   .host_rdata   (host_rdata),
   .irq_mask     (irq_mask),
   .irq_ack      (irq_ack),
   .irq_pend     (irq_pend),
   .irq          (irq)
);

// File: tb/test_ci_chan_ctrl.sv
module test_ci_chan_ctrl;
   localparam int CLK_P = 10;
   localparam int W     = 4;
   localparam logic [W-1:0] ONES = '1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         chan_en = 1'b0, loop_en = 1'b0, slot_stb = 1'b0;
   logic [W-1:0] rx_slot_data = '0, host_wdata = '0;
   logic         host_wr = 1'b0, irq_mask = 1'b0, irq_ack = 1'b0;
   logic [W-1:0] tx_slot_data, host_rdata;
   logic         irq;

   int n_chk = 0, n_err = 0;
   logic [W-1:0] ref_acc = '1, ref_cand = '1, ref_tx = '1;
   logic         ref_vld = 1'b0, ref_pend = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ci_chan_ctrl #(.CODE_W(W)) i_ci_chan_ctrl (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .loop_en(loop_en),
      .slot_stb(slot_stb), .rx_slot_data(rx_slot_data), .tx_slot_data(tx_slot_data),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq_mask(irq_mask), .irq_ack(irq_ack), .irq(irq)
   );

   task automatic chk(input int act, input int exp, input string rq);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic chk_out(input string rq);
      chk(host_rdata, ref_acc, rq);
      chk(irq, ref_pend & irq_mask, rq);
   endtask

   task automatic do_strobe(input logic [W-1:0] code, input logic ack, input string rq);
      logic [W-1:0] smp;
      @(negedge clk);
      rx_slot_data = code; slot_stb = 1'b1; irq_ack = ack;
      @(negedge clk);
      slot_stb = 1'b0; irq_ack = 1'b0;
      if (ack) ref_pend = 1'b0;
      if (chan_en) begin
         smp = loop_en ? ref_tx : code;
         if (ref_vld && smp == ref_cand) begin
            if (smp != ref_acc) begin
               ref_acc = smp; ref_pend = 1'b1;
            end
         end else begin
            ref_cand = smp; ref_vld = 1'b1;
         end
      end
      chk_out(rq);
   endtask

   task automatic do_ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      ref_pend = 1'b0;
      chk(irq, 0, "R8");
   endtask

   task automatic do_write(input logic [W-1:0] d);
      @(negedge clk); host_wr = 1'b1; host_wdata = d;
      @(negedge clk); host_wr = 1'b0;
      ref_tx = d;
      chk(tx_slot_data, chan_en ? d : ONES, "R1");
   endtask

   task automatic set_en(input logic v);
      @(negedge clk); chan_en = v;
      if (!v) ref_vld = 1'b0;
   endtask

   initial begin
      #(CLK_P * 200000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: reset state
      chk(host_rdata, ONES, "R2");
      chk(irq, 0, "R2");
      chk(tx_slot_data, ONES, "R2");
      set_en(1'b1);
      irq_mask = 1'b1;
      @(negedge clk);
      chk(tx_slot_data, ONES, "R2");
      chk(irq, 0, "R2");

      // R1: transmit hold and idle while disabled
      do_write(4'h6);
      repeat (5) @(negedge clk);
      chk(tx_slot_data, 6, "R1");
      do_write(4'hA);
      set_en(1'b0);
      @(negedge clk);
      chk(tx_slot_data, ONES, "R1");
      set_en(1'b1);
      @(negedge clk);
      chk(tx_slot_data, 10, "R1");

      // R3 R4: exhaustive sweep of consecutive code pairs
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            do_strobe(W'(a), 1'b0, "R3");
            do_strobe(W'(b), 1'b0, "R4");
            if (ref_pend) do_ack();
         end
      end

      // R5: repeat of the accepted code raises nothing
      do_strobe(4'h3, 1'b0, "R4");
      do_strobe(4'h3, 1'b0, "R4");
      do_ack();
      for (int i = 0; i < 4; i++) do_strobe(4'h3, 1'b0, "R5");
      chk(irq, 0, "R5");

      // R6: alternating codes never accepted
      for (int i = 0; i < 10; i++) do_strobe((i % 2) ? 4'h5 : 4'hC, 1'b0, "R6");
      chk(host_rdata, 3, "R6");

      // R7: mask hides but keeps pending
      irq_mask = 1'b0;
      do_strobe(4'h9, 1'b0, "R7");
      do_strobe(4'h9, 1'b0, "R7");
      chk(irq, 0, "R7");
      @(negedge clk); irq_mask = 1'b1;
      #1 chk(irq, 1, "R7");
      do_ack();

      // R8: acceptance wins over same-cycle acknowledge
      do_strobe(4'h2, 1'b0, "R8");
      do_strobe(4'h2, 1'b1, "R8");
      chk(irq, 1, "R8");
      do_ack();

      // R9: loopback takes transmit code, ignores line data
      do_write(4'hE);
      loop_en = 1'b1;
      do_strobe(4'h1, 1'b0, "R9");
      do_strobe(4'h1, 1'b0, "R9");
      chk(host_rdata, 14, "R9");
      loop_en = 1'b0;
      do_ack();

      // R10: disabled strobes ignored, candidate dropped
      set_en(1'b0);
      do_strobe(4'h7, 1'b0, "R10");
      do_strobe(4'h7, 1'b0, "R10");
      chk(host_rdata, 14, "R10");
      set_en(1'b1);
      do_strobe(4'h4, 1'b0, "R10");
      set_en(1'b0);
      set_en(1'b1);
      do_strobe(4'h4, 1'b0, "R10");
      chk(host_rdata, 14, "R10");
      chk(irq, 0, "R10");
      do_strobe(4'h4, 1'b0, "R10");
      chk(host_rdata, 4, "R10");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule